// File: doc/BRIEF.md
# Real-Time Clock Timebase and Rate Generator

This block is the front end of a real-time clock's timekeeping path. A clock enable that pulses once per 32.768 kHz oscillator period advances a 15-stage binary divider. From that divider the block derives a once-per-second update strobe for the calendar logic and a look-ahead busy flag that warns software before each update. It also produces a programmable periodic tick. That tick feeds a square-wave pin and a latched periodic interrupt flag.

An 8-bit control byte is read and written over a simple synchronous register port. It holds a 3-bit divider-control code and a 4-bit rate code. Its top bit returns the busy flag. The divider-control code starts the chain, stops it, or holds it cleared. The rate code picks one divider tap or silences the tick. A SET input blocks updates while software rewrites the time. Separate enables gate the square-wave pin and the interrupt.

Top module: `rtc_timebase`

## Requirements
- R1: The control byte reads as bit 7 = busy flag, bits 6:4 = divider-control code, bits 3:0 = rate code. A write loads bits 6:0. Bit 7 of a write is ignored.
- R2: Reset leaves the divider-control code and the rate code unchanged, and it clears the periodic flag.
- R3: Code 010 advances the divider by one on each oscillator enable. Codes 110 and 111 hold the divider at zero. Every other code freezes the divider at its present value.
- R4: Once the code changes from a held state to 010, the first update strobe comes 16384 oscillator enables later. After that a strobe comes every 32768 enables. Each strobe is one clock cycle long.
- R5: The busy flag rises 8 oscillator enables before an update strobe. It stays high through the strobe cycle and falls in the cycle after. An update strobe only ever occurs while the busy flag is high.
- R6: While SET is 1, no update strobe occurs and the busy flag is 0. The divider keeps counting, so the next update after SET is released lands on the unchanged one-second grid.
- R7: Rate code 1 selects 256 Hz and code 2 selects 128 Hz. Codes 3 through 15 select 8192 Hz, halving at each step down to 2 Hz at code 15. Divider bit k runs at 16384/2^k Hz.
- R8: The square-wave output is the selected tap ANDed with the square-wave enable. Rate code 0 holds it at 0.
- R9: The periodic flag sets on each rising edge of the selected tap. It clears on a flag-read strobe, and a set in the same cycle wins. The interrupt output is the flag ANDed with the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle enable per 32.768 kHz oscillator period |
| set_hold | input | 1 | Inhibits update strobes while software sets the time |
| sqw_en | input | 1 | Square-wave output enable |
| pie_en | input | 1 | Periodic interrupt enable |
| reg_wr | input | 1 | Control byte write strobe |
| reg_wdata | input | 8 | Control byte write data |
| flag_rd | input | 1 | Interrupt status read strobe, clears the periodic flag |
| reg_rdata | output | 8 | Control byte read data |
| update_pulse | output | 1 | One-cycle once-per-second update strobe |
| uip | output | 1 | Update-in-progress look-ahead flag |
| sqw_out | output | 1 | Square-wave output |
| periodic_flag | output | 1 | Latched periodic tick flag |
| periodic_irq | output | 1 | Periodic interrupt request |

## Verification
The embedded properties check on every cycle that each update strobe falls inside a busy window and lasts one cycle. They also check that SET silences both strobe and flag, that a held code zeroes the divider and a stopped code freezes it, that writes land and reset spares the control byte, and that a tap rise sets the flag. Only the bench scenarios can show the absolute timing: the 16384-enable first update, the 32768-enable period, the 8-enable busy lead, and the grid kept across a SET interval. The bench scenarios also cover the actual frequency of several rate codes, silence under code 0, and a frozen divider that holds the square wave steady.

// File: rtl/rtc_timebase_pkg.sv
package rtc_timebase_pkg;

    typedef enum logic [1:0] {
        CHAIN_STOP,
        CHAIN_RUN,
        CHAIN_HOLD
    } chain_mode_e;

    typedef struct packed {
        logic [2:0] dv;
        logic [3:0] rs;
    } ctrl_fields_t;

    function automatic chain_mode_e decode_dv(input logic [2:0] dv);
        if (dv == 3'b010)
            return CHAIN_RUN;
        else if (dv[2:1] == 2'b11)
            return CHAIN_HOLD;
        else
            return CHAIN_STOP;
    endfunction

    // divider bit index for a nonzero rate code
    function automatic int rs_to_tap(input logic [3:0] rs);
        case (rs)
            4'd1:    return 6;
            4'd2:    return 7;
            default: return int'(rs) - 2;
        endcase
    endfunction

endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
    import rtc_timebase_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         reg_wr,
    input  ctrl_fields_t wr_fields,
    output ctrl_fields_t fields
);

    // intentionally not reset: the control byte survives reset
    always_ff @(posedge clk) begin
        if (reg_wr)
            fields <= wr_fields;
    end

    AST_WR_LANDS: assert property (@(posedge clk)
        reg_wr |=> (fields == $past(wr_fields)));  // R1

    AST_RST_KEEPS_CTRL: assert property (@(posedge clk)
        (rst && !reg_wr) |=> $stable(fields));  // R2

endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
    import rtc_timebase_pkg::*;
#(
    parameter int DIV_STAGES = 15,
    parameter int UIP_LEAD   = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  osc_tick,
    input  logic                  set_hold,
    input  logic [2:0]            dv,
    output logic [DIV_STAGES-1:0] cnt,
    output logic                  update_pulse,
    output logic                  uip
);

    localparam logic [DIV_STAGES-1:0] LAST_BEFORE = {1'b0, {(DIV_STAGES-1){1'b1}}};
    localparam logic [DIV_STAGES-1:0] WARN_AT     = LAST_BEFORE - DIV_STAGES'(UIP_LEAD);

    chain_mode_e mode;
    assign mode = decode_dv(dv);

    always_ff @(posedge clk) begin
        if (mode == CHAIN_HOLD)
            cnt <= '0;
        else if (mode == CHAIN_RUN && osc_tick)
            cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        update_pulse <= (mode == CHAIN_RUN) && osc_tick && (cnt == LAST_BEFORE)
                        && uip && !set_hold;
    end

    always_ff @(posedge clk) begin
        if (set_hold || mode != CHAIN_RUN)
            uip <= 1'b0;
        else if (osc_tick && cnt == WARN_AT)
            uip <= 1'b1;
        else if (update_pulse)
            uip <= 1'b0;
    end

    AST_UPD_UNDER_UIP: assert property (@(posedge clk) disable iff (rst)
        update_pulse |-> uip);  // R5

    AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        update_pulse |=> !update_pulse);  // R4

    AST_SET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(set_hold) |-> (!update_pulse && !uip));  // R6

    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mode == CHAIN_HOLD) |=> (cnt == '0));  // R3

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (mode == CHAIN_STOP) |=> $stable(cnt));  // R3

endmodule

// File: rtl/rtc_rate_sel.sv
module rtc_rate_sel
    import rtc_timebase_pkg::*;
#(
    parameter int DIV_STAGES = 15
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [DIV_STAGES-1:0] cnt,
    input  logic [3:0]            rs,
    input  logic                  sqw_en,
    input  logic                  pie_en,
    input  logic                  flag_rd,
    output logic                  sqw_out,
    output logic                  pflag,
    output logic                  pirq
);

    int   tap_idx;
    logic tap;
    logic tap_prev;

    assign tap_idx = rs_to_tap(rs);

    always_comb begin
        tap = 1'b0;
        for (int i = 0; i < DIV_STAGES; i++) begin
            if (rs != 4'd0 && i == tap_idx)
                tap = cnt[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_prev <= 1'b0;
            pflag    <= 1'b0;
        end else begin
            tap_prev <= tap;
            if (tap && !tap_prev)
                pflag <= 1'b1;
            else if (flag_rd)
                pflag <= 1'b0;
        end
    end

    assign sqw_out = sqw_en & tap;
    assign pirq    = pie_en & pflag;

    AST_PF_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(tap) |=> pflag);  // R9

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        (rs == 4'd0) |-> !sqw_out);  // R8

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !pie_en |-> !pirq);  // R9

endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
    import rtc_timebase_pkg::*;
#(
    parameter int DIV_STAGES = 15,
    parameter int UIP_LEAD   = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_tick,
    input  logic       set_hold,
    input  logic       sqw_en,
    input  logic       pie_en,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    input  logic       flag_rd,
    output logic [7:0] reg_rdata,
    output logic       update_pulse,
    output logic       uip,
    output logic       sqw_out,
    output logic       periodic_flag,
    output logic       periodic_irq
);

    ctrl_fields_t          wr_fields;
    ctrl_fields_t          fields;
    logic [DIV_STAGES-1:0] cnt;
    logic                  wr_unused;

    assign wr_fields = '{dv: reg_wdata[6:4], rs: reg_wdata[3:0]};
    assign wr_unused = reg_wdata[7];

    rtc_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .wr_fields (wr_fields),
        .fields    (fields)
    );

    rtc_div_chain #(
        .DIV_STAGES (DIV_STAGES),
        .UIP_LEAD   (UIP_LEAD)
    ) u_chain (
        .clk          (clk),
        .rst          (rst),
        .osc_tick     (osc_tick),
        .set_hold     (set_hold),
        .dv           (fields.dv),
        .cnt          (cnt),
        .update_pulse (update_pulse),
        .uip          (uip)
    );

    rtc_rate_sel #(
        .DIV_STAGES (DIV_STAGES)
    ) u_rate (
        .clk     (clk),
        .rst     (rst),
        .cnt     (cnt),
        .rs      (fields.rs),
        .sqw_en  (sqw_en),
        .pie_en  (pie_en),
        .flag_rd (flag_rd),
        .sqw_out (sqw_out),
        .pflag   (periodic_flag),
        .pirq    (periodic_irq)
    );

    assign reg_rdata = {uip, fields.dv, fields.rs};

    AST_RD_BUSY_BIT: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[7] == uip);  // R1

endmodule

// File: tb/rtc_timebase_tb_top.sv
module rtc_timebase_tb_top;

    localparam int K_UPD = 0;
    localparam int K_UIP = 1;
    localparam int K_SQW = 2;
    localparam int K_PF  = 3;
    localparam int K_IRQ = 4;
    localparam int K_RD  = 5;

    typedef struct {
        int    cyc;
        int    kind;
        int    val;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b1;
    logic       set_hold = 1'b0;
    logic       sqw_en = 1'b1;
    logic       pie_en = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       flag_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       update_pulse, uip, sqw_out, periodic_flag, periodic_irq;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    exp_t exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rtc_timebase dut_i (
        .clk           (clk),
        .rst           (rst),
        .osc_tick      (osc_tick),
        .set_hold      (set_hold),
        .sqw_en        (sqw_en),
        .pie_en        (pie_en),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .flag_rd       (flag_rd),
        .reg_rdata     (reg_rdata),
        .update_pulse  (update_pulse),
        .uip           (uip),
        .sqw_out       (sqw_out),
        .periodic_flag (periodic_flag),
        .periodic_irq  (periodic_irq)
    );

    task automatic report();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    task automatic push(input int c, input int k, input int v, input string r);
        exp_t e;
        e.cyc = c; e.kind = k; e.val = v; e.req = r;
        exp_q.push_back(e);
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // write lands at the edge that ends cycle c
    task automatic wr(input int c, input logic [7:0] d);
        wait_to(c);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic int sample(input int k);
        case (k)
            K_UPD:   return int'(update_pulse);
            K_UIP:   return int'(uip);
            K_SQW:   return int'(sqw_out);
            K_PF:    return int'(periodic_flag);
            K_IRQ:   return int'(periodic_irq);
            default: return int'(reg_rdata);
        endcase
    endfunction

    // monitor: pops expectations due this cycle and compares
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
                exp_t e;
                int   got;
                e = exp_q.pop_front();
                n_chk++;
                got = sample(e.kind);
                if (e.cyc < cyc) begin
                    n_bad++;
                    $display("FAIL %s missed kind=%0d cyc=%0d got=none exp=%0d",
                             e.req, e.kind, e.cyc, e.val);
                end else if (got != e.val) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d cyc=%0d got=%0d exp=%0d",
                             e.req, e.kind, cyc, got, e.val);
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R4 got=running exp=finished");
        report();
    end

    // driver
    initial begin
        int w;
        int h;
        int w2;
        wait_to(3);
        push(4, K_PF,  0, "R2");
        push(4, K_UPD, 0, "R4");
        push(4, K_IRQ, 0, "R9");
        rst = 1'b0;
        wr(5, 8'h60);
        w = 9;
        push(w + 1, K_RD, 8'h2F, "R1");
        push(w + 2, K_RD, 8'h2F, "R1");
        push(13,    K_RD, 8'h2F, "R2");
        wr(8, 8'h2F);
        wr(w + 1, 8'hAF);
        wait_to(12); rst = 1'b1;
        wait_to(13); rst = 1'b0;

        push(w + 8191,  K_SQW, 0, "R8");
        push(w + 8192,  K_SQW, 1, "R7");
        push(w + 8192,  K_PF,  0, "R9");
        push(w + 8193,  K_PF,  1, "R9");
        push(w + 8193,  K_IRQ, 0, "R9");
        push(w + 9000,  K_IRQ, 1, "R9");
        push(w + 10000, K_PF,  1, "R9");
        push(w + 10001, K_PF,  0, "R9");
        push(w + 16375, K_UIP, 0, "R5");
        push(w + 16376, K_UIP, 1, "R5");
        push(w + 16383, K_UPD, 0, "R4");
        push(w + 16384, K_UPD, 1, "R4");
        push(w + 16384, K_UIP, 1, "R5");
        push(w + 16385, K_UPD, 0, "R4");
        push(w + 16385, K_UIP, 0, "R5");
        push(w + 24577, K_PF,  1, "R9");
        push(w + 49151, K_UPD, 0, "R4");
        push(w + 49152, K_UPD, 1, "R4");
        wait_to(w + 9000);  pie_en = 1'b1;
        wait_to(w + 10000); flag_rd = 1'b1;
        @(negedge clk);     flag_rd = 1'b0;

        wait_to(w + 49200);
        push(w + 81912,  K_UIP, 0, "R6");
        push(w + 81920,  K_UIP, 0, "R6");
        push(w + 81920,  K_UPD, 0, "R6");
        push(w + 81921,  K_UPD, 0, "R6");
        push(w + 114679, K_UIP, 0, "R5");
        push(w + 114680, K_UIP, 1, "R6");
        push(w + 114688, K_UPD, 1, "R6");
        wait_to(w + 50000); set_hold = 1'b1;
        wait_to(w + 82000); set_hold = 1'b0;

        wait_to(w + 114700);
        h = w + 115000;
        w2 = h + 11;
        push(h + 1,       K_RD,  8'h6F, "R1");
        push(h + 5,       K_SQW, 0, "R3");
        push(w2 + 16383,  K_UPD, 0, "R3");
        push(w2 + 16384,  K_UPD, 1, "R4");
        push(w2 + 24577,  K_PF,  0, "R9");
        push(w2 + 24600,  K_SQW, 0, "R8");
        push(w2 + 30016,  K_SQW, 1, "R7");
        push(w2 + 30080,  K_SQW, 0, "R7");
        push(w2 + 30102,  K_SQW, 1, "R7");
        push(w2 + 30104,  K_SQW, 0, "R7");
        push(w2 + 30210,  K_SQW, 1, "R3");
        push(w2 + 30300,  K_SQW, 1, "R3");
        push(w2 + 30300,  K_RD,  8'h03, "R1");
        wr(h, 8'h6F);
        wr(h + 10, 8'h2F);
        wait_to(w2 + 19999);
        reg_wr = 1'b1; reg_wdata = 8'h20; flag_rd = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; flag_rd = 1'b0;
        wr(w2 + 29999, 8'h21);
        wr(w2 + 30099, 8'h23);
        wr(w2 + 30202, 8'h03);

        wait_to(w2 + 30310);
        if (exp_q.size() != 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R4 leftover got=%0d exp=0", exp_q.size());
        end
        report();
    end

endmodule